// File: doc/BRIEF.md
# Three-Stage Pipeline Branch Controller

This block holds the control state of an in-order pipeline with three stages: fetch (F), decode (D) and execute (E). Each cycle it decides whether every stage advances, holds or is killed. Instruction memory is an abstract source: the block shows a fetch address, and the source answers in the same cycle with a token for that address. The token gives a class, an address-register-use flag, a delay-mode bit, a condition outcome, a transfer count and a branch target. The block reports the valid bit of each stage, the fetch address with any redirect already applied, and a trace of the instructions that finish.

Branch conditions are only known in E. Each branch carries its own mode bit. In delayed mode the two instructions after the branch always run. In immediate mode a taken branch throws away the younger work already in flight. A multi-register transfer keeps E busy for one cycle per register, and everything younger waits behind it. If an address register is written by one instruction and read by the next one, one bubble is placed between them.

The execute sequencer has two states. FLOW is the state for single-cycle work. HOLD is the state while a multi-register transfer still has cycles left. The transition FLOW->HOLD happens when a transfer with a count above one enters E. HOLD->HOLD counts down the remaining cycles. HOLD->FLOW happens on the last of those cycles, so the transfer finishes in FLOW.

Top module: `brpipe_ctrl`

## Requirements
- R1: While reset is asserted, all three stage valid bits are 0, the fetch address is 0 and no retirement is reported.
- R2: Token class codes on `i_op` are 0 plain, 1 multi-register transfer, 2 branch and 3 address-register write. With no hazards, one token enters F per cycle and the fetch address goes up by one. The instruction fetched after the first rising edge following reset retires after the third edge, and later instructions retire one cycle apart.
- R3: A taken branch (`i_cond_taken`=1 at fetch) is resolved while it sits in E. In that cycle `o_redirect` is 1 and `o_fetch_pc` shows the branch target, so the target is fetched on the next edge.
- R4: For a branch with `i_delay_mode`=1, the two sequentially following instructions always retire, right after the branch. If the branch is taken, the target retires next, with no lost cycle.
- R5: For a taken branch with `i_delay_mode`=0, the two younger instructions are squashed and never retire. The target retires three cycles after the branch, so two bubbles are lost.
- R6: A branch that is not taken, in either mode, causes no squash and no bubble. The next sequential instruction retires in the following cycle.
- R7: A multi-register transfer with count field c (a count of 0 acts as 1) occupies E for max(c,1) cycles. During the extra cycles the fetch address and the younger stages hold.
- R8: When an address-register write (class 3) is in E and the token in D has `i_uses_areg`=1, one bubble enters E. The use retires two cycles after the write. If another instruction lies between them, no bubble is added.
- R9: `o_ret_valid` pulses once per completed instruction, in its last E cycle, with `o_ret_pc` giving its fetch address. The retired order matches the sequential program under the delay-slot rules.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock, rising edge active |
| rst_n | input | 1 | Active-low synchronous reset |
| i_op | input | 2 | Class of the token at `o_fetch_pc` |
| i_uses_areg | input | 1 | Token reads an address register |
| i_delay_mode | input | 1 | Branch uses delayed mode |
| i_cond_taken | input | 1 | Branch condition outcome, used in E |
| i_xfer_count | input | CNT_W | Registers moved by a multi-register transfer |
| i_target | input | PC_W | Branch target address |
| o_fetch_pc | output | PC_W | Address fetched on the next edge |
| o_redirect | output | 1 | A taken branch is steering fetch this cycle |
| o_stage_valid | output | 3 | Valid bits, {E, D, F} |
| o_ret_valid | output | 1 | An instruction completes this cycle |
| o_ret_pc | output | PC_W | Address of the completing instruction |

## Verification
Retirement comes out combinationally from E. Counting edges from the release of reset, each instruction's retirement is therefore due on an exact edge: the previous one plus one, plus max(c,1)-1 for a transfer, plus one after an address-register write feeding a use, plus two after a taken immediate-mode branch. The bench works out that edge for every retirement from a sequential walk of the program, with delay-slot rules. It samples at the falling edge, after the count has moved, and compares both the address and the edge number. The redirect flag and the target on the fetch address are checked in the same cycle the branch retires, because both are driven from the same E contents.

// File: rtl/brpipe_pkg.sv
package brpipe_pkg;

    typedef enum logic [1:0] {
        OP_PLAIN  = 2'd0,
        OP_MULTI  = 2'd1,
        OP_BRANCH = 2'd2,
        OP_AWRITE = 2'd3
    } op_e;

    typedef struct packed {
        op_e  op;
        logic uses_areg;
        logic delayed;
        logic taken;
    } ctl_t;

    typedef enum logic {
        EX_FLOW = 1'b0,
        EX_HOLD = 1'b1
    } ex_state_e;

    localparam int unsigned STAGES = 3;
    localparam int unsigned SF = 0;
    localparam int unsigned SD = 1;
    localparam int unsigned SE = 2;

endpackage

// File: rtl/brpipe_exec_fsm.sv
module brpipe_exec_fsm
    import brpipe_pkg::*;
#(
    parameter int unsigned CNT_W = 3
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             i_load,
    input  logic             i_multi,
    input  logic [CNT_W-1:0] i_count,
    output logic             o_hold
);

    localparam logic [CNT_W-1:0] ONE = CNT_W'(1);

    ex_state_e        state_q, state_d;
    logic [CNT_W-1:0] left_q, left_d;

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            state_q <= EX_FLOW;
            left_q  <= '0;
        end else begin
            state_q <= state_d;
            left_q  <= left_d;
        end
    end

    always_comb begin
        state_d = state_q;
        left_d  = left_q;
        o_hold  = 1'b0;
        unique case (state_q)
            EX_FLOW: begin
                if (i_load && i_multi && (i_count > ONE)) begin
                    state_d = EX_HOLD;
                    left_d  = i_count - ONE;
                end
            end
            EX_HOLD: begin
                o_hold = 1'b1;
                left_d = left_q - ONE;
                if (left_q == ONE) begin
                    state_d = EX_FLOW;
                end
            end
            default: state_d = EX_FLOW;
        endcase
    end

    // R7: a hold is always backed by remaining cycles
    a_r7_hold_has_cycles: assert property (@(posedge clk) disable iff (!rst_n)
        (state_q == EX_HOLD) |-> (left_q != '0));

    // R7: the last counted cycle returns the sequencer to FLOW
    a_r7_hold_ends: assert property (@(posedge clk) disable iff (!rst_n)
        (state_q == EX_HOLD && left_q == ONE) |=> (state_q == EX_FLOW));

endmodule

// File: rtl/brpipe_hazard.sv
module brpipe_hazard
    import brpipe_pkg::*;
(
    input  logic e_valid,
    input  ctl_t e_ctl,
    input  logic d_valid,
    input  ctl_t d_ctl,
    input  logic hold,
    output logic o_redirect,
    output logic o_squash,
    output logic o_interlock,
    output logic o_advance
);

    always_comb begin
        o_redirect  = e_valid && (e_ctl.op == OP_BRANCH) && e_ctl.taken && !hold;
        o_squash    = o_redirect && !e_ctl.delayed;
        o_interlock = !hold && e_valid && (e_ctl.op == OP_AWRITE)
                      && d_valid && d_ctl.uses_areg;
        o_advance   = !hold && !o_interlock;
    end

endmodule

// File: rtl/brpipe_ctrl.sv
module brpipe_ctrl
    import brpipe_pkg::*;
#(
    parameter int unsigned PC_W  = 8,
    parameter int unsigned CNT_W = 3
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic [1:0]       i_op,
    input  logic             i_uses_areg,
    input  logic             i_delay_mode,
    input  logic             i_cond_taken,
    input  logic [CNT_W-1:0] i_xfer_count,
    input  logic [PC_W-1:0]  i_target,
    output logic [PC_W-1:0]  o_fetch_pc,
    output logic             o_redirect,
    output logic [2:0]       o_stage_valid,
    output logic             o_ret_valid,
    output logic [PC_W-1:0]  o_ret_pc
);

    localparam logic [PC_W-1:0] PC_ONE = PC_W'(1);

    logic             valid_q [STAGES];
    logic [PC_W-1:0]  pc_q    [STAGES];
    ctl_t             ctl_q   [STAGES];
    logic [CNT_W-1:0] cnt_q   [STAGES];
    logic [PC_W-1:0]  tgt_q   [STAGES];
    logic [PC_W-1:0]  fetch_q;

    logic hold, redirect, squash, interlock, advance;
    logic en   [STAGES];
    logic keep [STAGES];
    ctl_t in_ctl;

    brpipe_hazard u_hazard (
        .e_valid     (valid_q[SE]),
        .e_ctl       (ctl_q[SE]),
        .d_valid     (valid_q[SD]),
        .d_ctl       (ctl_q[SD]),
        .hold        (hold),
        .o_redirect  (redirect),
        .o_squash    (squash),
        .o_interlock (interlock),
        .o_advance   (advance)
    );

    brpipe_exec_fsm #(.CNT_W(CNT_W)) u_exec (
        .clk     (clk),
        .rst_n   (rst_n),
        .i_load  (!hold),
        .i_multi (valid_q[SD] && !squash && !interlock && (ctl_q[SD].op == OP_MULTI)),
        .i_count (cnt_q[SD]),
        .o_hold  (hold)
    );

    always_comb begin
        in_ctl.op        = op_e'(i_op);
        in_ctl.uses_areg = i_uses_areg;
        in_ctl.delayed   = i_delay_mode;
        in_ctl.taken     = i_cond_taken;
        en[SF]   = advance;
        keep[SF] = 1'b1;
        en[SD]   = advance;
        keep[SD] = !squash;
        en[SE]   = !hold;
        keep[SE] = !squash && !interlock;
    end

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            fetch_q <= '0;
            for (int s = 0; s < STAGES; s++) begin
                valid_q[s] <= 1'b0;
                pc_q[s]    <= '0;
                ctl_q[s]   <= '0;
                cnt_q[s]   <= '0;
                tgt_q[s]   <= '0;
            end
        end else begin
            if (en[SF]) begin
                valid_q[SF] <= 1'b1;
                pc_q[SF]    <= o_fetch_pc;
                ctl_q[SF]   <= in_ctl;
                cnt_q[SF]   <= i_xfer_count;
                tgt_q[SF]   <= i_target;
                fetch_q     <= o_fetch_pc + PC_ONE;
            end
            for (int s = 1; s < STAGES; s++) begin
                if (en[s]) begin
                    valid_q[s] <= valid_q[s-1] && keep[s];
                    pc_q[s]    <= pc_q[s-1];
                    ctl_q[s]   <= ctl_q[s-1];
                    cnt_q[s]   <= cnt_q[s-1];
                    tgt_q[s]   <= tgt_q[s-1];
                end
            end
        end
    end

    always_comb begin
        o_fetch_pc    = redirect ? tgt_q[SE] : fetch_q;
        o_redirect    = redirect;
        o_stage_valid = {valid_q[SE], valid_q[SD], valid_q[SF]};
        o_ret_valid   = valid_q[SE] && !hold;
        o_ret_pc      = pc_q[SE];
    end

    // R5: an immediate-mode taken branch empties D and E behind it
    a_r5_squash_kills: assert property (@(posedge clk) disable iff (!rst_n)
        squash |=> (!valid_q[SD] && !valid_q[SE]));

    // R3: the target lands in F on the edge after resolution
    a_r3_target_fetched: assert property (@(posedge clk) disable iff (!rst_n)
        redirect |=> (valid_q[SF] && pc_q[SF] == $past(tgt_q[SE])));

    // R4: in delayed mode the first slot moves into E
    a_r4_slot_advances: assert property (@(posedge clk) disable iff (!rst_n)
        (redirect && !squash && valid_q[SD]) |=> (valid_q[SE] && pc_q[SE] == $past(pc_q[SD])));

    // R8: the interlock puts a bubble in E and keeps the user in D
    a_r8_bubble: assert property (@(posedge clk) disable iff (!rst_n)
        interlock |=> (!valid_q[SE] && valid_q[SD] && pc_q[SD] == $past(pc_q[SD])));

    // R7: younger work and fetch hold while the transfer occupies E
    a_r7_stall_holds: assert property (@(posedge clk) disable iff (!rst_n)
        hold |=> ($stable(fetch_q) && $stable(pc_q[SE]) && $stable(pc_q[SD])));

endmodule

// File: tb/brpipe_ctrl_tb.sv
module brpipe_ctrl_tb;

    localparam int PERIOD = 10;
    localparam int PC_W   = 8;
    localparam int CNT_W  = 3;
    localparam int MEM    = 1 << PC_W;
    localparam int NRET   = 30;
    localparam int LIMIT  = 200;

    logic             clk = 1'b0;
    logic             rst_n = 1'b0;
    logic [1:0]       i_op;
    logic             i_uses_areg, i_delay_mode, i_cond_taken;
    logic [CNT_W-1:0] i_xfer_count;
    logic [PC_W-1:0]  i_target;
    logic [PC_W-1:0]  o_fetch_pc, o_ret_pc;
    logic             o_redirect, o_ret_valid;
    logic [2:0]       o_stage_valid;

    logic [1:0]       m_op  [MEM];
    logic             m_use [MEM];
    logic             m_dl  [MEM];
    logic             m_tk  [MEM];
    logic [CNT_W-1:0] m_cnt [MEM];
    logic [PC_W-1:0]  m_tgt [MEM];

    int e_pc [NRET];
    int e_cyc[NRET];
    int e_tag[NRET];

    int errors = 0;
    int checks = 0;
    bit done = 0;

    always #(PERIOD/2) clk = ~clk;

    assign i_op         = m_op[o_fetch_pc];
    assign i_uses_areg  = m_use[o_fetch_pc];
    assign i_delay_mode = m_dl[o_fetch_pc];
    assign i_cond_taken = m_tk[o_fetch_pc];
    assign i_xfer_count = m_cnt[o_fetch_pc];
    assign i_target     = m_tgt[o_fetch_pc];

    brpipe_ctrl #(.PC_W(PC_W), .CNT_W(CNT_W)) u_dut (
        .clk(clk), .rst_n(rst_n),
        .i_op(i_op), .i_uses_areg(i_uses_areg), .i_delay_mode(i_delay_mode),
        .i_cond_taken(i_cond_taken), .i_xfer_count(i_xfer_count), .i_target(i_target),
        .o_fetch_pc(o_fetch_pc), .o_redirect(o_redirect), .o_stage_valid(o_stage_valid),
        .o_ret_valid(o_ret_valid), .o_ret_pc(o_ret_pc)
    );

    task automatic chk(input bit ok, input string tag, input int act, input int exp);
        checks++;
        if (!ok) begin
            errors++;
            $display("FAIL %s actual=%0d expected=%0d at %0t", tag, act, exp, $time);
        end
    endtask

    task automatic load_prog(input bit dl, input bit tk, input int cnt, input int gap);
        for (int a = 0; a < MEM; a++) begin
            m_op[a] = 2'd0; m_use[a] = 1'b0; m_dl[a] = 1'b0; m_tk[a] = 1'b0;
            m_cnt[a] = '0;  m_tgt[a] = '0;
        end
        m_op[1] = 2'd1; m_cnt[1] = CNT_W'(cnt);
        m_op[2] = 2'd3;
        m_use[3 + gap] = 1'b1;
        m_op[6] = 2'd2; m_dl[6] = dl; m_tk[6] = tk; m_tgt[6] = 8'd20;
        m_op[8] = 2'd3;
        m_use[20] = 1'b1;
        m_op[21] = 2'd3;
        m_use[22] = 1'b1;
        m_op[25] = 2'd2; m_dl[25] = !dl; m_tk[25] = 1'b1; m_tgt[25] = 8'd40;
        m_op[41] = 2'd1; m_cnt[41] = CNT_W'(7);
    endtask

    // tag codes: 2 plain, 4 delayed, 5 squash, 6 not taken, 7 transfer, 8 interlock
    task automatic build_ref();
        int pc = 0, pend = 0, ptgt = 0, prevc = 0, c, npc;
        bit prev_aw = 0, prev_sq = 0, prev_dly = 0, inter;
        int slots = 0;
        for (int n = 0; n < NRET; n++) begin
            c = (n == 0) ? 3 : prevc + 1;
            if (prev_sq) c += 2;
            inter = prev_aw && m_use[pc];
            if (inter) c += 1;
            if (m_op[pc] == 2'd1 && m_cnt[pc] > 1) c += int'(m_cnt[pc]) - 1;
            e_pc[n]  = pc;
            e_cyc[n] = c;
            if (m_op[pc] == 2'd1) e_tag[n] = 7;
            else if (inter) e_tag[n] = 8;
            else if (prev_sq) e_tag[n] = 5;
            else if (slots > 0 || prev_dly) e_tag[n] = 4;
            else if (m_op[pc] == 2'd2 && !m_tk[pc]) e_tag[n] = 6;
            else e_tag[n] = 2;
            prev_dly = (slots == 1) && (pend == 1);
            npc = pc + 1;
            if (pend > 0) begin
                pend--;
                if (pend == 0) npc = ptgt;
            end
            slots = pend;
            if (m_op[pc] == 2'd2 && m_tk[pc]) begin
                if (m_dl[pc]) begin pend = 2; ptgt = int'(m_tgt[pc]); slots = 2; end
                else npc = int'(m_tgt[pc]);
            end
            prev_sq = (m_op[pc] == 2'd2) && m_tk[pc] && !m_dl[pc];
            prev_aw = (m_op[pc] == 2'd3);
            prevc = c;
            pc = npc;
        end
    endtask

    function automatic string tagname(input int t);
        case (t)
            4: return "R4";
            5: return "R5";
            6: return "R6";
            7: return "R7";
            8: return "R8";
            default: return "R2";
        endcase
    endfunction

    task automatic run_case(input bit dl, input bit tk, input int cnt, input int gap);
        int cyc = 0;
        int n = 0;
        load_prog(dl, tk, cnt, gap);
        build_ref();
        @(negedge clk);
        rst_n = 1'b0;
        repeat (2) @(posedge clk);
        @(negedge clk);
        chk(o_stage_valid == 3'b000, "R1 stage valid", int'(o_stage_valid), 0);
        chk(o_fetch_pc == '0, "R1 fetch pc", int'(o_fetch_pc), 0);
        chk(!o_ret_valid, "R1 retire", int'(o_ret_valid), 0);
        rst_n = 1'b1;
        while (n < NRET && cyc < LIMIT) begin
            @(posedge clk);
            cyc++;
            @(negedge clk);
            if (o_ret_valid) begin
                chk(int'(o_ret_pc) == e_pc[n], "R9 retired order", int'(o_ret_pc), e_pc[n]);
                chk(cyc == e_cyc[n], tagname(e_tag[n]), cyc, e_cyc[n]);
                if (m_op[o_ret_pc] == 2'd2) begin
                    chk(o_redirect == m_tk[o_ret_pc], "R3 redirect flag",
                        int'(o_redirect), int'(m_tk[o_ret_pc]));
                    if (m_tk[o_ret_pc])
                        chk(o_fetch_pc == m_tgt[o_ret_pc], "R3 fetch target",
                            int'(o_fetch_pc), int'(m_tgt[o_ret_pc]));
                end else begin
                    chk(!o_redirect, "R6 no redirect", int'(o_redirect), 0);
                end
                n++;
            end
        end
        chk(n == NRET, "R9 retire count", n, NRET);
    endtask

    initial begin
        for (int m = 0; m < 4; m++) begin
            for (int lc = 0; lc < 4; lc++) begin
                for (int g = 0; g < 3; g++) begin
                    run_case(m[1], m[0], (lc == 3) ? 7 : lc, g);
                end
            end
        end
        if (!done) begin
            done = 1;
            $display("Result: errors=%0d of %0d checks", errors, checks);
            $finish;
        end
    end

    initial begin
        repeat (100000) @(posedge clk);
        if (!done) begin
            done = 1;
            errors++;
            checks++;
            $display("FAIL watchdog actual=timeout expected=finish");
            $display("Result: errors=%0d of %0d checks", errors, checks);
            $finish;
        end
    end

endmodule